// File: doc/BRIEF.md
# Register-Mapped Digital I/O Port with Pull-Ups

This block is the general-purpose pin port of a small 8-bit microcontroller. The CPU reaches it through three I/O addresses. One holds an output latch, one holds a direction register, and one returns the sampled pin levels without storing anything. The port serves five push-pull pins (0 to 4) and one extra pin (5). Pin 5 can only be an input or an open-drain output. For every pin the block drives an output-enable, an output value and a pull-up enable towards an external pad cell, and it samples the pad's input level.

The latch has two jobs. It gives the level of an output pin, and it turns on the pull-up of an input pin. A global pull-up-disable input, taken from a control register elsewhere, turns all pull-ups off. Pad levels pass through a synchronizer before the CPU can read them. Reset releases every pin at once, with or without a running clock.

The CPU bus is a plain register interface. A write takes effect on the clock edge where the strobe is high. Read data is combinational from the address, so there is no handshake and no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, all `pad_oe` and `pad_pu` bits are 0. After reset, the latch and the direction register read as 0.
- R2: A write to address 0x18 loads `wdata[4:0]` into the latch. Reading 0x18 returns the latch in bits 4..0, with bits 7..5 read as 0. It returns the latch, never the pin levels.
- R3: A write to address 0x17 loads `wdata[4:0]` into the direction bits 4..0. When `OD_PIN_EN`=1 it also loads `wdata[5]` into direction bit 5. Reading 0x17 returns the direction bits, with bits 7..6 read as 0, and bit 5 read as 0 when `OD_PIN_EN`=0.
- R4: Reading address 0x16 returns `pad_in[5:0]` in bits 5..0, as sampled two clock edges earlier, with bits 7..6 read as 0. Writes to 0x16 change neither the latch nor the direction register.
- R5: For pins 0..4, a direction bit of 1 sets `pad_oe`=1 and `pad_out` equal to the latch bit. A direction bit of 0 sets `pad_oe`=0.
- R6: For pins 0..4, `pad_pu` is 1 exactly when the direction bit is 0, the latch bit is 1 and `pull_off` is 0.
- R7: Pin 5 has `pad_out`=0 and `pad_pu`=0 at all times. Its `pad_oe` equals its direction bit, so when driven the pin only pulls low.
- R8: Driving `rst_n` low drops every `pad_oe` and `pad_pu` to 0 at once, without waiting for a clock edge.
- R9: Addresses other than 0x16, 0x17 and 0x18 read as 0, and writes to them change no state.
- R10: With `wr_en` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | I/O address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pull_off | input | 1 | Global pull-up disable |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Pad output enables |
| pad_out | output | 6 | Pad output values |
| pad_pu | output | 6 | Pad pull-up enables |

## Verification
The assertions check, on every cycle, the following rules:
- Pad controls are released during reset.
- A write to the direction or latch address appears on the pad enables or values one edge later.
- No pull-up is on while `pull_off` is high or while the pin drives.
- Pin 5 never drives high.
- The sample read matches the pad level of two edges earlier.

Other behaviours show only in the bench's scenarios. These are the full mapping from every latch and direction pair to the pad controls, the read-back masks, the release of the pads by an asynchronous reset between edges, and that writes to the sample address, to unmapped addresses or with the strobe low leave the state unchanged.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int ADDR_SAMPLE = 'h16;
  localparam int ADDR_DIR    = 'h17;
  localparam int ADDR_LATCH  = 'h18;
endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs #(
  parameter int ADDR_W    = 6,
  parameter int DW        = 8,
  parameter int PP_PINS   = 5,
  parameter bit OD_PIN_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [PP_PINS:0]   wbits,
  output logic [PP_PINS-1:0] latch_q,
  output logic [PP_PINS:0]   dir_q
);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(gpio_pkg::ADDR_LATCH);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(gpio_pkg::ADDR_DIR);

  logic wr_latch, wr_dir;
  assign wr_latch = wr_en && (addr == A_LATCH);
  assign wr_dir   = wr_en && (addr == A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (wr_latch) latch_q <= wbits[PP_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q[PP_PINS-1:0] <= '0;
    else if (wr_dir) dir_q[PP_PINS-1:0] <= wbits[PP_PINS-1:0];
  end

  generate
    if (OD_PIN_EN) begin : g_od_dir
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q[PP_PINS] <= 1'b0;
        else if (wr_dir) dir_q[PP_PINS] <= wbits[PP_PINS];
      end
    end else begin : g_in_only
      logic unused_od_bit;
      assign unused_od_bit = wbits[PP_PINS];
      assign dir_q[PP_PINS] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= '0;
        else        st[s] <= st[s-1];
      end
    end
  endgenerate

  assign dout = st[STAGES-1];
endmodule

// File: rtl/gpio_padctl.sv
`timescale 1ns/1ps
module gpio_padctl #(
  parameter int PP_PINS = 5
) (
  input  logic               rst_n,
  input  logic               pull_off,
  input  logic [PP_PINS-1:0] latch_q,
  input  logic [PP_PINS:0]   dir_q,
  output logic [PP_PINS:0]   oe,
  output logic [PP_PINS:0]   out,
  output logic [PP_PINS:0]   pu
);
  generate
    for (genvar i = 0; i < PP_PINS; i++) begin : g_pp
      assign oe[i]  = rst_n & dir_q[i];
      assign out[i] = latch_q[i];
      assign pu[i]  = rst_n & ~dir_q[i] & latch_q[i] & ~pull_off;
    end
  endgenerate

  // open-drain pin: drives low only, no pull-up
  assign oe[PP_PINS]  = rst_n & dir_q[PP_PINS];
  assign out[PP_PINS] = 1'b0;
  assign pu[PP_PINS]  = 1'b0;
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port #(
  parameter int ADDR_W      = 6,
  parameter int DW          = 8,
  parameter int PP_PINS     = 5,
  parameter bit OD_PIN_EN   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic                 pull_off,
  input  logic [PP_PINS:0]     pad_in,
  output logic [PP_PINS:0]     pad_oe,
  output logic [PP_PINS:0]     pad_out,
  output logic [PP_PINS:0]     pad_pu
);
  localparam int NPINS = PP_PINS + 1;
  localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(gpio_pkg::ADDR_LATCH);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(gpio_pkg::ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_SAMPLE = ADDR_W'(gpio_pkg::ADDR_SAMPLE);

  logic [PP_PINS-1:0] latch_q;
  logic [PP_PINS:0]   dir_q;
  logic [PP_PINS:0]   sampled;
  logic               unused_wdata;

  assign unused_wdata = ^wdata[DW-1:NPINS];

  gpio_regs #(
    .ADDR_W(ADDR_W), .DW(DW), .PP_PINS(PP_PINS), .OD_PIN_EN(OD_PIN_EN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wbits(wdata[NPINS-1:0]), .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sampled)
  );

  gpio_padctl #(.PP_PINS(PP_PINS)) u_pad (
    .rst_n(rst_n), .pull_off(pull_off), .latch_q(latch_q), .dir_q(dir_q),
    .oe(pad_oe), .out(pad_out), .pu(pad_pu)
  );

  always_comb begin
    if (addr == A_LATCH)       rdata = DW'(latch_q);
    else if (addr == A_DIR)    rdata = DW'(dir_q);
    else if (addr == A_SAMPLE) rdata = DW'(sampled);
    else                       rdata = '0;
  end
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk #(
  parameter int ADDR_W    = 6,
  parameter int DW        = 8,
  parameter int PP_PINS   = 5,
  parameter bit OD_PIN_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic              pull_off,
  input logic [PP_PINS:0]  pad_in,
  input logic [PP_PINS:0]  pad_oe,
  input logic [PP_PINS:0]  pad_out,
  input logic [PP_PINS:0]  pad_pu
);
  localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(gpio_pkg::ADDR_LATCH);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(gpio_pkg::ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_SAMPLE = ADDR_W'(gpio_pkg::ADDR_SAMPLE);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

  // R5
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == A_DIR) |->
      pad_oe[PP_PINS-1:0] == $past(wdata[PP_PINS-1:0]));

  // R3
  od_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == A_DIR) |->
      pad_oe[PP_PINS] == ($past(wdata[PP_PINS]) && OD_PIN_EN));

  // R2
  latch_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == A_LATCH) |->
      pad_out[PP_PINS-1:0] == $past(wdata[PP_PINS-1:0]));

  // R6
  pull_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_off |-> pad_pu == '0);

  // R6
  no_pull_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R7
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[PP_PINS] |-> !pad_out[PP_PINS]);

  // R4
  sample_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && addr == A_SAMPLE) |->
      rdata[PP_PINS:0] == $past(pad_in, 2));
endmodule

bind gpio_port gpio_port_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .PP_PINS(PP_PINS), .OD_PIN_EN(OD_PIN_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pull_off(pull_off), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pull_off = 1'b0;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_oe, pad_out, pad_pu;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pull_off(pull_off), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 6'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    addr = 6'(a);
    #0.5;
    v = rdata;
  endtask

  initial begin
    logic [7:0] v;
    // R1 reset state
    #1;
    check(pad_oe, 0, "R1 oe in reset");
    check(pad_pu, 0, "R1 pu in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd('h18, v); check(v, 0, "R1 latch after reset");
    rd('h17, v); check(v, 0, "R1 dir after reset");

    // R2 / R3 masks
    wr('h18, 'hFF); rd('h18, v); check(v, 'h1F, "R2 latch readback mask");
    wr('h17, 'hFF); rd('h17, v); check(v, 'h3F, "R3 dir readback mask");
    pad_in = 6'h00;
    repeat (2) @(negedge clk);
    rd('h18, v); check(v, 'h1F, "R2 latch read is not pins");

    // R5 R6 R7 full sweep of latch x direction x pull_off
    for (int l = 0; l < 32; l++) begin
      for (int d = 0; d < 64; d++) begin
        wr('h18, l);
        wr('h17, d);
        for (int p = 0; p < 2; p++) begin
          logic [5:0] eoe, eout, epu;
          pull_off = p[0];
          #0.5;
          eoe  = 6'(d);
          eout = {1'b0, 5'(l)};
          epu  = p[0] ? 6'h0 : {1'b0, 5'(l) & ~5'(d)};
          check({pad_oe, pad_out, pad_pu}, {eoe, eout, epu}, "R5 R6 R7 pad map");
        end
      end
    end
    pull_off = 1'b0;

    // R4 sample path, sweep all pad levels
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      pad_in = 6'(k ^ 'h2A);
      @(negedge clk);
      @(negedge clk);
      rd('h16, v); check(v, 8'(k ^ 'h2A), "R4 sample after two edges");
    end
    // R4 writes to sample address ignored
    wr('h18, 'h0A); wr('h17, 'h15);
    wr('h16, 'hFF);
    rd('h18, v); check(v, 'h0A, "R4 write to sample leaves latch");
    rd('h17, v); check(v, 'h15, "R4 write to sample leaves dir");

    // R9 unmapped addresses
    for (int a = 0; a < 64; a++) begin
      if (a != 'h16 && a != 'h17 && a != 'h18) begin
        wr(a, 'hFF);
        rd(a, v); check(v, 0, "R9 unmapped read");
      end
    end
    rd('h18, v); check(v, 'h0A, "R9 latch unchanged");
    rd('h17, v); check(v, 'h15, "R9 dir unchanged");

    // R10 no strobe
    for (int a = 'h16; a <= 'h18; a++) begin
      @(negedge clk);
      addr = 6'(a); wdata = 8'hFF; wr_en = 1'b0;
      @(negedge clk);
    end
    rd('h18, v); check(v, 'h0A, "R10 latch unchanged without strobe");
    rd('h17, v); check(v, 'h15, "R10 dir unchanged without strobe");

    // R8 asynchronous reset between edges
    wr('h18, 'h1F); wr('h17, 'h20);
    check(pad_oe, 'h20, "R8 setup oe");
    check(pad_pu, 'h1F, "R8 setup pu");
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(pad_oe, 0, "R8 oe drops without clock");
    check(pad_pu, 0, "R8 pu drops without clock");
    @(negedge clk);
    rst_n = 1'b1;
    rd('h17, v); check(v, 0, "R1 dir cleared by reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule